// File: doc/BRIEF.md
# Serial EEPROM Identification Autoloader

After reset this block reads identification words from a three-wire serial EEPROM and fills two 32-bit identification registers that the host sees through configuration reads. One register holds the vendor and device identifiers and the other holds the subsystem vendor and subsystem identifiers. The block drives the EEPROM chip select, serial clock and serial data toward the memory. It samples the serial data that comes back. It raises a done flag once every word has been captured.

The word at address 3Eh acts as a sentinel. If it reads all ones, a built-in default vendor/device pair, set by a parameter, goes into the identification register and the device word at 3Dh is never fetched. Otherwise the words at 3Eh and 3Dh are used. The subsystem words at 36h and 35h are always loaded. Until loading is complete, every configuration read is answered with a retry and never with a partly filled value.

Top module: `eeid_loader`

## Requirements
- R1: While reset is high and on the first cycle after it, `ee_cs`, `ee_sk`, `load_done`, `cfg_rd_ack` and `cfg_rd_retry` are all low.
- R2: Each word read opens with a 9-bit command sent MSB first on `ee_mosi`: start bit 1, opcode bits 1 then 0, then the 6-bit word address MSB first. `ee_mosi` changes only while `ee_sk` is low, so the memory can sample it on the rising edge of `ee_sk`.
- R3: After the ninth rising edge, the memory presents 16 data bits MSB first, each one after a falling edge of `ee_sk`. The block samples one bit on each of the next 16 rising edges.
- R4: Words are fetched in the order 3Eh, 3Dh, 36h, 35h. The fetch of 3Dh is skipped when word 3Eh is FFFFh.
- R5: When word 3Eh is FFFFh, the identification register takes the `DEFAULT_ID` parameter (vendor in bits 15:0, device in bits 31:16).
- R6: When word 3Eh is not FFFFh, the identification register is {word 3Dh, word 3Eh}, with the vendor in bits 15:0.
- R7: The subsystem register is {word 35h, word 36h}, with the subsystem vendor in bits 15:0 and the subsystem identifier in bits 31:16.
- R8: `ee_sk` is high for `SK_HALF` clocks and low for `SK_HALF` clocks within a read. `ee_sk` is low whenever `ee_cs` is low. Between two reads, `ee_cs` stays low for at least 2*`SK_HALF` clocks.
- R9: `load_done` rises only after the last word has been captured and `ee_cs` has dropped. Once high, it stays high until reset, and `ee_cs` stays low.
- R10: A configuration read (`cfg_rd_req` high) while `load_done` is low is answered one cycle later with `cfg_rd_retry` high, `cfg_rd_ack` low and `cfg_rd_data` zero.
- R11: A configuration read while `load_done` is high is answered one cycle later with `cfg_rd_ack` high and the selected register on `cfg_rd_data`: `cfg_rd_sel` = 0 selects the identification register and 1 selects the subsystem register. Without a request, neither response strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_mosi | output | 1 | Serial data to the EEPROM (command and address) |
| ee_miso | input | 1 | Serial data from the EEPROM |
| cfg_rd_req | input | 1 | Configuration read request, one cycle per read |
| cfg_rd_sel | input | 1 | 0: identification register, 1: subsystem register |
| cfg_rd_ack | output | 1 | Read answered with valid data |
| cfg_rd_retry | output | 1 | Read refused because loading is still under way |
| cfg_rd_data | output | 32 | Read data, zero unless acknowledged |
| load_done | output | 1 | All identification words are loaded |

## Verification
Some rules are checked on every cycle: the serial clock is quiet while chip select is low, the data toward the memory holds still while the clock is high, the done flag is sticky and keeps chip select low, and reads get a retry or an acknowledge according to the done flag. Other behaviour shows only in the bench scenarios, where a model of the memory answers with chosen words. These cover the fetch order and the skipping of 3Dh, the choice between the sentinel and the default pair, the placement of each 16-bit word and of its bits, the serial clock period, and the chip-select gap between reads.

// File: rtl/eeid_pkg.sv
package eeid_pkg;
  localparam int unsigned EE_WORD_W = 16;
  localparam int unsigned EE_ADDR_W = 6;
  localparam logic [2:0]  EE_RD_CMD = 3'b110;  // start bit, then read opcode 10

  typedef enum logic [1:0] {SH_IDLE, SH_CMD, SH_DATA, SH_GAP} sh_state_t;
  typedef enum logic [1:0] {SQ_ISSUE, SQ_WAIT, SQ_DRAIN, SQ_DONE} sq_state_t;
endpackage

// File: rtl/eeid_tick.sv
module eeid_tick #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  generate
    if (HALF <= 1) begin : g_every
      assign tick = en;
    end else begin : g_count
      localparam int unsigned CW = $clog2(HALF);
      localparam logic [CW-1:0] LAST = CW'(HALF - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !en) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = en && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/eeid_shifter.sv
module eeid_shifter
  import eeid_pkg::*;
#(
  parameter int unsigned AW = EE_ADDR_W,
  parameter int unsigned DW = EE_WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic          tick,
  input  logic          miso,
  output logic          cs,
  output logic          sk,
  output logic          mosi,
  output logic          busy,
  output logic          word_valid,
  output logic [DW-1:0] word
);
  localparam int unsigned CW    = 3 + AW;
  localparam int unsigned CNT_W = $clog2(CW > DW ? CW : DW);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CW - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DW - 1);

  sh_state_t     state;
  logic [CNT_W-1:0] cnt;
  logic [CW-1:0] cmd_sr;
  logic [DW-1:0] data_sr;
  logic [CW-1:0] cmd_word;

  assign cmd_word = {EE_RD_CMD, addr};
  assign busy     = (state != SH_IDLE);
  assign word     = data_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SH_IDLE;
      cs         <= 1'b0;
      sk         <= 1'b0;
      mosi       <= 1'b0;
      cnt        <= '0;
      cmd_sr     <= '0;
      data_sr    <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      case (state)
        SH_IDLE: begin
          if (start) begin
            cs     <= 1'b1;
            sk     <= 1'b0;
            mosi   <= cmd_word[CW-1];
            cmd_sr <= cmd_word << 1;
            cnt    <= '0;
            state  <= SH_CMD;
          end
        end
        SH_CMD: begin
          if (tick) begin
            if (!sk) begin
              sk <= 1'b1;
            end else begin
              sk <= 1'b0;
              if (cnt == CMD_LAST) begin
                cnt   <= '0;
                mosi  <= 1'b0;
                state <= SH_DATA;
              end else begin
                cnt    <= cnt + 1'b1;
                mosi   <= cmd_sr[CW-1];
                cmd_sr <= cmd_sr << 1;
              end
            end
          end
        end
        SH_DATA: begin
          if (tick) begin
            if (!sk) begin
              sk      <= 1'b1;
              data_sr <= {data_sr[DW-2:0], miso};
            end else begin
              sk <= 1'b0;
              if (cnt == DATA_LAST) begin
                cnt        <= '0;
                cs         <= 1'b0;
                word_valid <= 1'b1;
                state      <= SH_GAP;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
        end
        default: begin  // SH_GAP: chip select low for two ticks
          if (tick) begin
            if (cnt == CNT_W'(1)) begin
              cnt   <= '0;
              state <= SH_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/eeid_seq.sv
module eeid_seq
  import eeid_pkg::*;
#(
  parameter int unsigned  AW         = EE_ADDR_W,
  parameter int unsigned  DW         = EE_WORD_W,
  parameter logic [AW-1:0] VEN_ADDR  = 6'h3E,
  parameter logic [AW-1:0] DEV_ADDR  = 6'h3D,
  parameter logic [AW-1:0] SSV_ADDR  = 6'h36,
  parameter logic [AW-1:0] SSID_ADDR = 6'h35,
  parameter logic [2*DW-1:0] DEFAULT_ID = 32'h7E11_C0DE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sh_busy,
  input  logic            sh_valid,
  input  logic [DW-1:0]   sh_word,
  output logic            sh_start,
  output logic [AW-1:0]   sh_addr,
  output logic            done,
  output logic [2*DW-1:0] id_word,
  output logic [2*DW-1:0] sub_word
);
  localparam logic [DW-1:0] SENTINEL = {DW{1'b1}};

  sq_state_t    state;
  logic [1:0]   step;
  logic         last;
  logic         use_default;
  logic [DW-1:0] ven_w, dev_w, ssv_w, ssid_w;

  always_comb begin
    case (step)
      2'd0:    sh_addr = VEN_ADDR;
      2'd1:    sh_addr = DEV_ADDR;
      2'd2:    sh_addr = SSV_ADDR;
      default: sh_addr = SSID_ADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_ISSUE;
      step        <= 2'd0;
      last        <= 1'b0;
      use_default <= 1'b0;
      sh_start    <= 1'b0;
      done        <= 1'b0;
      ven_w       <= '0;
      dev_w       <= '0;
      ssv_w       <= '0;
      ssid_w      <= '0;
      id_word     <= '0;
      sub_word    <= '0;
    end else begin
      sh_start <= 1'b0;
      case (state)
        SQ_ISSUE: begin
          sh_start <= 1'b1;
          state    <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (sh_valid) begin
            state <= SQ_DRAIN;
            case (step)
              2'd0: begin
                ven_w       <= sh_word;
                use_default <= (sh_word == SENTINEL);
                step        <= (sh_word == SENTINEL) ? 2'd2 : 2'd1;
              end
              2'd1: begin
                dev_w <= sh_word;
                step  <= 2'd2;
              end
              2'd2: begin
                ssv_w <= sh_word;
                step  <= 2'd3;
              end
              default: begin
                ssid_w <= sh_word;
                last   <= 1'b1;
              end
            endcase
          end
        end
        SQ_DRAIN: begin
          if (!sh_busy) begin
            if (last) begin
              done     <= 1'b1;
              id_word  <= use_default ? DEFAULT_ID : {dev_w, ven_w};
              sub_word <= {ssid_w, ssv_w};
              state    <= SQ_DONE;
            end else begin
              state <= SQ_ISSUE;
            end
          end
        end
        default: ;  // SQ_DONE holds until reset
      endcase
    end
  end
endmodule

// File: rtl/eeid_loader.sv
module eeid_loader
  import eeid_pkg::*;
#(
  parameter int unsigned   SK_HALF    = 4,
  parameter int unsigned   ADDR_W     = EE_ADDR_W,
  parameter int unsigned   WORD_W     = EE_WORD_W,
  parameter logic [ADDR_W-1:0] VEN_ADDR  = 6'h3E,
  parameter logic [ADDR_W-1:0] DEV_ADDR  = 6'h3D,
  parameter logic [ADDR_W-1:0] SSV_ADDR  = 6'h36,
  parameter logic [ADDR_W-1:0] SSID_ADDR = 6'h35,
  parameter logic [2*WORD_W-1:0] DEFAULT_ID = 32'h7E11_C0DE
) (
  input  logic                clk,
  input  logic                rst,
  output logic                ee_cs,
  output logic                ee_sk,
  output logic                ee_mosi,
  input  logic                ee_miso,
  input  logic                cfg_rd_req,
  input  logic                cfg_rd_sel,
  output logic                cfg_rd_ack,
  output logic                cfg_rd_retry,
  output logic [2*WORD_W-1:0] cfg_rd_data,
  output logic                load_done
);
  logic              tick, sh_busy, sh_valid, sh_start;
  logic [WORD_W-1:0] sh_word;
  logic [ADDR_W-1:0] sh_addr;
  logic [2*WORD_W-1:0] id_word, sub_word;

  eeid_tick #(.HALF(SK_HALF)) u_tick (
    .clk(clk), .rst(rst), .en(sh_busy), .tick(tick)
  );

  eeid_shifter #(.AW(ADDR_W), .DW(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .addr(sh_addr), .tick(tick),
    .miso(ee_miso), .cs(ee_cs), .sk(ee_sk), .mosi(ee_mosi),
    .busy(sh_busy), .word_valid(sh_valid), .word(sh_word)
  );

  eeid_seq #(
    .AW(ADDR_W), .DW(WORD_W), .VEN_ADDR(VEN_ADDR), .DEV_ADDR(DEV_ADDR),
    .SSV_ADDR(SSV_ADDR), .SSID_ADDR(SSID_ADDR), .DEFAULT_ID(DEFAULT_ID)
  ) u_seq (
    .clk(clk), .rst(rst), .sh_busy(sh_busy), .sh_valid(sh_valid),
    .sh_word(sh_word), .sh_start(sh_start), .sh_addr(sh_addr),
    .done(load_done), .id_word(id_word), .sub_word(sub_word)
  );

  // Configuration read port: answered one cycle after the request.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rd_ack   <= 1'b0;
      cfg_rd_retry <= 1'b0;
      cfg_rd_data  <= '0;
    end else begin
      cfg_rd_ack   <= cfg_rd_req && load_done;
      cfg_rd_retry <= cfg_rd_req && !load_done;
      if (cfg_rd_req && load_done) cfg_rd_data <= cfg_rd_sel ? sub_word : id_word;
      else                         cfg_rd_data <= '0;
    end
  end
endmodule

// File: rtl/eeid_loader_chk.sv
module eeid_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        ee_mosi,
  input logic        cfg_rd_req,
  input logic        cfg_rd_ack,
  input logic        cfg_rd_retry,
  input logic [31:0] cfg_rd_data,
  input logic        load_done
);
  p_sk_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sk);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (ee_cs && ee_sk && $past(ee_sk)) |-> $stable(ee_mosi));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    load_done |=> load_done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    load_done |-> !ee_cs);

  p_retry_early_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_req && !load_done) |=> (cfg_rd_retry && !cfg_rd_ack && cfg_rd_data == 32'd0));

  p_ack_late_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_req && load_done) |=> (cfg_rd_ack && !cfg_rd_retry));

  p_no_resp_r11: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd_req |=> (!cfg_rd_ack && !cfg_rd_retry));
endmodule

bind eeid_loader eeid_loader_chk u_chk (
  .clk(clk), .rst(rst), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_mosi(ee_mosi),
  .cfg_rd_req(cfg_rd_req), .cfg_rd_ack(cfg_rd_ack), .cfg_rd_retry(cfg_rd_retry),
  .cfg_rd_data(cfg_rd_data), .load_done(load_done)
);

// File: tb/tb_eeid_loader.sv
module tb_eeid_loader;
  localparam int CLK_PERIOD = 10;
  localparam int SK_HALF    = 2;
  localparam logic [31:0] DEF_ID = 32'h7E11_C0DE;

  logic clk = 1'b0, rst = 1'b1;
  logic ee_cs, ee_sk, ee_mosi, ee_miso = 1'b0;
  logic cfg_rd_req = 1'b0, cfg_rd_sel = 1'b0;
  logic cfg_rd_ack, cfg_rd_retry, load_done;
  logic [31:0] cfg_rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeid_loader #(.SK_HALF(SK_HALF), .DEFAULT_ID(DEF_ID)) dut (
    .clk(clk), .rst(rst), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_mosi(ee_mosi),
    .ee_miso(ee_miso), .cfg_rd_req(cfg_rd_req), .cfg_rd_sel(cfg_rd_sel),
    .cfg_rd_ack(cfg_rd_ack), .cfg_rd_retry(cfg_rd_retry),
    .cfg_rd_data(cfg_rd_data), .load_done(load_done)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- EEPROM model and address scoreboard ----------------
  logic [15:0] w3e, w3d, w36, w35;
  logic [5:0]  exp_addr_q[$];
  int cyc = 0;
  always @(posedge clk) cyc++;

  function automatic logic [15:0] rom(input logic [5:0] a);
    case (a)
      6'h3E: return w3e;
      6'h3D: return w3d;
      6'h36: return w36;
      6'h35: return w35;
      default: return 16'h0000;
    endcase
  endfunction

  int bitn = 0, outn = 0, last_rise = -1, last_fall_cs = -1;
  logic [8:0]  cmd = '0;
  logic [15:0] rdw = '0;
  logic prev_sk = 0, prev_cs = 0;

  always @(negedge clk) begin
    if (rst) begin
      bitn = 0; outn = 0; last_rise = -1; last_fall_cs = -1;
    end else begin
      if (ee_cs && !prev_cs && last_fall_cs >= 0)
        check(cyc - last_fall_cs >= 2*SK_HALF, "R8 cs gap", cyc - last_fall_cs, 2*SK_HALF);
      if (!ee_cs && prev_cs) last_fall_cs = cyc;
      if (!ee_cs) begin
        bitn = 0; outn = 0; last_rise = -1;
      end else begin
        if (ee_sk && !prev_sk) begin
          if (last_rise >= 0)
            check(cyc - last_rise == 2*SK_HALF, "R8 sk period", cyc - last_rise, 2*SK_HALF);
          last_rise = cyc;
          if (bitn < 9) begin
            cmd = {cmd[7:0], ee_mosi};
            bitn++;
            if (bitn == 9) begin
              check(cmd[8:6] == 3'b110, "R2 start/opcode", {29'd0, cmd[8:6]}, 32'd6);
              if (exp_addr_q.size() == 0) begin
                check(0, "R4 unexpected read", {26'd0, cmd[5:0]}, 32'hFFFF_FFFF);
              end else begin
                logic [5:0] ea;
                ea = exp_addr_q.pop_front();
                check(cmd[5:0] == ea, "R4 address order", {26'd0, cmd[5:0]}, {26'd0, ea});
              end
              rdw = rom(cmd[5:0]);
            end
          end
        end
        if (!ee_sk && prev_sk && bitn == 9 && outn < 16) begin
          ee_miso = rdw[15-outn];
          outn++;
        end
      end
    end
    prev_sk = ee_sk;
    prev_cs = ee_cs;
  end

  // ---------------- configuration read scoreboard ----------------
  bit          exp_ack_q[$];
  logic [31:0] exp_dat_q[$];
  string       exp_tag_q[$];

  always @(negedge clk) begin
    if (!rst && (cfg_rd_ack || cfg_rd_retry)) begin
      if (exp_ack_q.size() == 0) begin
        check(0, "R11 unrequested response", {31'd0, cfg_rd_ack}, 32'd0);
      end else begin
        bit ea; logic [31:0] ed; string et;
        ea = exp_ack_q.pop_front(); ed = exp_dat_q.pop_front(); et = exp_tag_q.pop_front();
        check(cfg_rd_ack == ea && cfg_rd_retry == !ea, {et, " strobe"}, {31'd0, cfg_rd_ack}, {31'd0, ea});
        check(cfg_rd_data == ed, {et, " data"}, cfg_rd_data, ed);
      end
    end
  end

  task automatic cfg_read(input bit sel, input bit exp_ack, input logic [31:0] exp_data, input string tag);
    @(negedge clk);
    cfg_rd_req = 1'b1; cfg_rd_sel = sel;
    exp_ack_q.push_back(exp_ack); exp_dat_q.push_back(exp_data); exp_tag_q.push_back(tag);
    @(negedge clk);
    cfg_rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input logic [15:0] a3e, a3d, a36, a35,
                     input logic [31:0] exp_id, exp_sub, input string name);
    w3e = a3e; w3d = a3d; w36 = a36; w35 = a35;
    exp_addr_q.delete();
    exp_addr_q.push_back(6'h3E);
    if (a3e != 16'hFFFF) exp_addr_q.push_back(6'h3D);
    exp_addr_q.push_back(6'h36);
    exp_addr_q.push_back(6'h35);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!ee_cs && !ee_sk && !load_done && !cfg_rd_ack && !cfg_rd_retry, {"R1 reset ", name},
          {27'd0, ee_cs, ee_sk, load_done, cfg_rd_ack, cfg_rd_retry}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!load_done && !cfg_rd_ack && !cfg_rd_retry, {"R1 after reset ", name},
          {29'd0, load_done, cfg_rd_ack, cfg_rd_retry}, 32'd0);
    cfg_read(1'b0, 1'b0, 32'd0, {"R10 early id ", name});
    cfg_read(1'b1, 1'b0, 32'd0, {"R10 early sub ", name});
    for (int i = 0; i < 5000 && !load_done; i++) @(negedge clk);
    check(load_done, {"R9 done seen ", name}, {31'd0, load_done}, 32'd1);
    check(exp_addr_q.size() == 0, {"R4/R9 all words before done ", name}, exp_addr_q.size(), 32'd0);
    check(!ee_cs, {"R9 cs low at done ", name}, {31'd0, ee_cs}, 32'd0);
    cfg_read(1'b0, 1'b1, exp_id, {"R3/R5/R6/R11 id ", name});
    cfg_read(1'b1, 1'b1, exp_sub, {"R3/R7/R11 sub ", name});
    repeat (20) @(negedge clk);
    check(load_done && !ee_cs && !ee_sk, {"R9 sticky ", name}, {29'd0, load_done, ee_cs, ee_sk}, 32'd4);
    check(exp_ack_q.size() == 0, {"R11 pending reads ", name}, exp_ack_q.size(), 32'd0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    run(16'h1234, 16'hABCD, 16'h8001, 16'h0A0F, 32'hABCD_1234, 32'h0A0F_8001, "loaded");
    run(16'hFFFF, 16'h5A5A, 16'h1111, 16'h2222, DEF_ID,        32'h2222_1111, "sentinel");
    run(16'hFFFE, 16'h0000, 16'hFFFF, 16'h7FFF, 32'h0000_FFFE, 32'h7FFF_FFFF, "near_sentinel");
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule